// File: doc/BRIEF.md
# Codec Clock-Reset Bring-Up Sequencer

This block sits on the host side of a codec/DSP device and takes the device from power-down to a running clock. On `start` it raises the device's power-down pin. It waits one millisecond. It then writes the clock-generation registers over a byte-wide serial-port handshake while the device is still held in clock reset. If asked to, it opens a program/coefficient download window around a download-ready bit. It then releases clock reset, which starts the device's PLL, and reports `ready` once the PLL has settled.

Two ways of ending the PLL wait are supported. The first is a fixed ten-millisecond wait. The second follows a lock indication, with a timeout that flags an error and powers the device down. Once the block is ready, a clock-change request puts the device back into clock reset, writes the new clock mode and releases the reset again. All delays are counted from the `CLK_KHZ` parameter, which gives the number of clock cycles per millisecond.

Top module: `codec_clkrst_seq`

## Requirements
- R1: A `start` seen while idle or in error drives `pdn_n` high on the next edge. No serial byte is offered until exactly `CLK_KHZ` cycles after `pdn_n` rises.
- R2: Each register write is a command byte followed by a data byte, each taken on a cycle with `spi_valid` and `spi_ready` both high. `spi_cs` stays high from the command byte until the data byte is taken. `spi_cs` is low in the cycle after each data byte is taken.
- R3: At bring-up the first write is 0xC0 0x08 (analog-input enable alone), sent only when `ain_en` is set. Next comes 0xC0 with data {0, mode[2:0], ain, 000}, with the mode at bits 6:4 and the analog enable at bit 3. Then comes 0xC1 0x00.
- R4: With `dl_en` set, 0xCF 0x01 follows the clock writes. `dl_open` rises `CLK_KHZ`+1 negedge samples after that write is taken. It stays high, with no serial traffic, until `dl_done`. Then 0xCF 0x00 is written.
- R5: Command 0xC0 is only sent while the clock-reset bit is 0, meaning before any 0xC1 0x01 or after a 0xC1 0x00. Every sequence ends with the release write 0xC1 0x01.
- R6: With `lock_mode`=0, `ready` is first seen 10·`CLK_KHZ`+1 negedge samples after the release write is taken. `pll_lock` is ignored in this mode.
- R7: With `lock_mode`=1, `ready` stays low until `pll_lock` rises. `pll_lock` passes through two flip-flops, so `ready` is seen exactly three samples after `pll_lock` is driven high.
- R8: With `lock_mode`=1 and no lock, `err` is first seen 20·`CLK_KHZ`+1 samples after the release write. In error, `busy`, `ready` and `pdn_n` are all low.
- R9: After reset `busy`, `ready`, `err` and `pdn_n` are low. `busy` is high from the accepted request until `ready` or `err`. At most one of `busy`, `ready` and `err` is high at any time.
- R10: In ready, `clk_change_req` triggers the writes 0xC1 0x00, then 0xC0 {0, new mode, ain, 000}, then 0xC1 0x01, followed by the PLL wait again.
- R11: `clk_change_req` outside ready and `start` while busy have no effect on traffic or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin bring-up (idle or error only) |
| clk_change_req | input | 1 | Request a clock-mode change (ready only) |
| clk_mode | input | 3 | Clock mode written to bits 6:4 of register 0xC0 |
| ain_en | input | 1 | Use the analog inputs (enable written first) |
| dl_en | input | 1 | Open a download window during bring-up |
| lock_mode | input | 1 | 0: fixed PLL wait, 1: wait for lock with timeout |
| dl_done | input | 1 | Host finished the download |
| pll_lock | input | 1 | Asynchronous PLL lock indication from the device |
| spi_ready | input | 1 | Serial shifter accepts the offered byte |
| pdn_n | output | 1 | Device power-down pin, high = powered |
| spi_cs | output | 1 | Chip select for the current write |
| spi_valid | output | 1 | A byte is offered |
| spi_data | output | 8 | Offered byte |
| dl_open | output | 1 | Download window open |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Device clock running and settled |
| err | output | 1 | Lock timeout |

## Verification
The main sequence is run four ways.

1. A full bring-up with the analog option and download window, in timer mode. It separates the optional first write and the download bracket from the clock writes, and shows that a lock pulse cannot shorten the fixed wait.
2. A clock change in lock mode. It shows the reversed write order and that `ready` tracks the synchronised lock.
3. A second clock change with no lock. It exposes the timeout path and the power-down on error.
4. A restart from error with both options off. It shows that the optional writes drop out and the one-millisecond gate holds again.

The serial shifter stalls one cycle in three throughout, so every handshake is exercised while waiting.

// File: rtl/codec_clkrst_seq.sv
module codec_clkrst_seq #(
  parameter int CLK_KHZ    = 200000,
  parameter int PLL_MS     = 10,
  parameter int LOCK_TO_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       clk_change_req,
  input  logic [2:0] clk_mode,
  input  logic       ain_en,
  input  logic       dl_en,
  input  logic       lock_mode,
  input  logic       dl_done,
  input  logic       pll_lock,
  input  logic       spi_ready,
  output logic       pdn_n,
  output logic       spi_cs,
  output logic       spi_valid,
  output logic [7:0] spi_data,
  output logic       dl_open,
  output logic       busy,
  output logic       ready,
  output logic       err
);
  localparam int MS_CYC  = CLK_KHZ;
  localparam int PLL_CYC = PLL_MS * CLK_KHZ;
  localparam int LTO_CYC = LOCK_TO_MS * CLK_KHZ;
  localparam int MAX_CYC = (PLL_CYC > LTO_CYC) ? PLL_CYC : LTO_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PDW, S_AIN, S_CK0, S_CK1R, S_DLON, S_DLW, S_DLOPEN,
    S_DLOFF, S_CKREL, S_PLL, S_READY, S_ERR
  } st_t;

  st_t          st, nxt;
  logic [TW-1:0] tmr;
  logic         phase, gap;
  logic [2:0]   mode_q;
  logic         ain_q, dl_q, lkm_q, chg_q;
  logic         lk_ff1, lk_s;
  logic [7:0]   cmd, dat;
  logic         wr_st, hs, done, idle_like;

  assign wr_st = st inside {S_AIN, S_CK0, S_CK1R, S_DLON, S_DLOFF, S_CKREL};
  assign spi_valid = wr_st && !gap;
  assign spi_cs    = spi_valid;
  assign spi_data  = phase ? dat : cmd;
  assign hs        = spi_valid && spi_ready;
  assign done      = hs && phase;
  assign idle_like = (st == S_IDLE) || (st == S_ERR);

  assign pdn_n   = !idle_like;
  assign dl_open = (st == S_DLOPEN);
  assign ready   = (st == S_READY);
  assign err     = (st == S_ERR);
  assign busy    = !idle_like && !ready;

  always_comb begin
    cmd = 8'hC1;
    dat = 8'h00;
    case (st)
      S_AIN:   begin cmd = 8'hC0; dat = 8'h08; end
      S_CK0:   begin cmd = 8'hC0; dat = {1'b0, mode_q, ain_q, 3'b000}; end
      S_DLON:  begin cmd = 8'hCF; dat = 8'h01; end
      S_DLOFF: begin cmd = 8'hCF; dat = 8'h00; end
      S_CKREL: begin cmd = 8'hC1; dat = 8'h01; end
      default: ;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE, S_ERR: if (start) nxt = S_PDW;
      S_PDW:    if (tmr == TW'(MS_CYC - 1)) nxt = ain_q ? S_AIN : S_CK0;
      S_AIN:    if (done) nxt = S_CK0;
      S_CK0:    if (done) nxt = chg_q ? S_CKREL : S_CK1R;
      S_CK1R:   if (done) nxt = chg_q ? S_CK0 : (dl_q ? S_DLON : S_CKREL);
      S_DLON:   if (done) nxt = S_DLW;
      S_DLW:    if (tmr == TW'(MS_CYC - 1)) nxt = S_DLOPEN;
      S_DLOPEN: if (dl_done) nxt = S_DLOFF;
      S_DLOFF:  if (done) nxt = S_CKREL;
      S_CKREL:  if (done) nxt = S_PLL;
      S_PLL: begin
        if (!lkm_q) begin
          if (tmr == TW'(PLL_CYC - 1)) nxt = S_READY;
        end else if (lk_s) begin
          nxt = S_READY;
        end else if (tmr == TW'(LTO_CYC - 1)) begin
          nxt = S_ERR;
        end
      end
      S_READY:  if (clk_change_req) nxt = S_CK1R;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      phase  <= 1'b0;
      gap    <= 1'b0;
      mode_q <= '0;
      ain_q  <= 1'b0;
      dl_q   <= 1'b0;
      lkm_q  <= 1'b0;
      chg_q  <= 1'b0;
      lk_ff1 <= 1'b0;
      lk_s   <= 1'b0;
    end else begin
      st     <= nxt;
      tmr    <= (nxt != st) ? '0 : tmr + 1'b1;
      gap    <= done;
      lk_ff1 <= pll_lock;
      lk_s   <= lk_ff1;
      if (hs) phase <= !phase;
      if (idle_like && start) begin
        mode_q <= clk_mode;
        ain_q  <= ain_en;
        dl_q   <= dl_en;
        lkm_q  <= lock_mode;
        chg_q  <= 1'b0;
      end
      if (ready && clk_change_req) begin
        mode_q <= clk_mode;
        lkm_q  <= lock_mode;
        chg_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/codec_clkrst_seq_chk.sv
module codec_clkrst_seq_chk #(
  parameter int MS_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pdn_n,
  input logic       spi_cs,
  input logic       spi_valid,
  input logic       spi_ready,
  input logic [7:0] spi_data,
  input logic       dl_open,
  input logic       busy,
  input logic       ready,
  input logic       err
);
  int         cnt;
  logic       ph, rel;
  logic [7:0] cmd_q;
  logic       hs;
  assign hs = spi_valid && spi_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !pdn_n) begin
      cnt <= 0;
      rel <= 1'b0;
    end else if (cnt < MS_CYC) begin
      cnt <= cnt + 1;
    end
    if (!rst_n) begin
      ph    <= 1'b0;
      cmd_q <= '0;
    end else if (hs) begin
      ph <= !ph;
      if (!ph) cmd_q <= spi_data;
      else if (cmd_q == 8'hC1 && pdn_n) rel <= spi_data[0];
    end
  end

  // R1
  early_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_valid |-> cnt >= MS_CYC);
  // R2
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph |-> spi_cs);
  // R2
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && ph) |=> !spi_cs);
  // R5
  clksel_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_valid && !ph && spi_data == 8'hC0) |-> !rel);
  // R4
  dl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_open |-> !spi_valid);
  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, ready, err}));
endmodule

bind codec_clkrst_seq codec_clkrst_seq_chk #(.MS_CYC(MS_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .spi_cs(spi_cs),
  .spi_valid(spi_valid), .spi_ready(spi_ready), .spi_data(spi_data),
  .dl_open(dl_open), .busy(busy), .ready(ready), .err(err)
);

// File: tb/codec_clkrst_seq_bench.sv
`timescale 1ns/1ps
module codec_clkrst_seq_bench;
  localparam int KHZ = 8;
  localparam int MS  = KHZ;
  localparam int PLL = 10 * KHZ;
  localparam int LTO = 20 * KHZ;

  logic clk = 0, rst_n = 0;
  logic start = 0, clk_change_req = 0, ain_en = 0, dl_en = 0, lock_mode = 0;
  logic dl_done = 0, pll_lock = 0, spi_ready = 0;
  logic [2:0] clk_mode = 0;
  logic pdn_n, spi_cs, spi_valid, dl_open, busy, ready, err;
  logic [7:0] spi_data;

  codec_clkrst_seq #(.CLK_KHZ(KHZ), .PLL_MS(10), .LOCK_TO_MS(20)) u_codec_clkrst_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_change_req(clk_change_req),
    .clk_mode(clk_mode), .ain_en(ain_en), .dl_en(dl_en), .lock_mode(lock_mode),
    .dl_done(dl_done), .pll_lock(pll_lock), .spi_ready(spi_ready),
    .pdn_n(pdn_n), .spi_cs(spi_cs), .spi_valid(spi_valid), .spi_data(spi_data),
    .dl_open(dl_open), .busy(busy), .ready(ready), .err(err));

  always #2.5 clk = !clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string cur_req = "R3";
  int first_valid_cyc = -1, last_wr_cyc = 0, n_bytes = 0;
  logic mph = 0, exp_gap = 0;
  logic [7:0] mcmd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic push_wr(input logic [7:0] c, input logic [7:0] d);
    exp_q.push_back({c, d});
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_gap) begin
        chk(!spi_cs, "R2", spi_cs, 0);
        exp_gap = 0;
      end
      if (spi_valid && spi_ready) begin
        if (first_valid_cyc < 0) first_valid_cyc = cyc;
        n_bytes++;
        chk(spi_cs, "R2", spi_cs, 1);
        if (!mph) begin
          mcmd = spi_data; mph = 1;
        end else begin
          mph = 0; last_wr_cyc = cyc; exp_gap = 1;
          if (exp_q.size() == 0) chk(0, cur_req, {mcmd, spi_data}, 16'hFFFF);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk({mcmd, spi_data} == e, cur_req, {mcmd, spi_data}, e);
          end
        end
      end
    end
  end

  // Serial shifter stalls one cycle in three
  initial begin
    forever begin
      @(negedge clk); spi_ready = 1;
      @(negedge clk); spi_ready = 1;
      @(negedge clk); spi_ready = 0;
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, rel;
    repeat (4) @(negedge clk);
    // R9 / R1 reset state
    chk(!busy && !ready && !err, "R9", {busy, ready, err}, 0);
    chk(!pdn_n && !spi_valid, "R1", {pdn_n, spi_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // R11 change request while idle
    pulse(clk_change_req);
    repeat (20) @(negedge clk);
    chk(!busy && !pdn_n && n_bytes == 0, "R11", {busy, pdn_n, n_bytes[5:0]}, 0);

    // Bring-up with analog option and download, timer mode
    cur_req = "R3"; ain_en = 1; dl_en = 1; clk_mode = 3'b011; lock_mode = 0;
    push_wr(8'hC0, 8'h08); push_wr(8'hC0, 8'h38); push_wr(8'hC1, 8'h00);
    push_wr(8'hCF, 8'h01); push_wr(8'hCF, 8'h00); push_wr(8'hC1, 8'h01);
    first_valid_cyc = -1;
    pulse(start);
    t0 = cyc;
    chk(pdn_n, "R1", pdn_n, 1);
    chk(busy, "R9", busy, 1);
    while (first_valid_cyc < 0) @(negedge clk);
    chk(first_valid_cyc - t0 == MS, "R1", first_valid_cyc - t0, MS);
    while (!dl_open) @(negedge clk);
    chk(cyc - last_wr_cyc == MS + 1, "R4", cyc - last_wr_cyc, MS + 1);
    chk(exp_q.size() == 2, "R4", exp_q.size(), 2);
    pulse(start);
    repeat (10) @(negedge clk);
    chk(dl_open && !spi_valid, "R4", {dl_open, spi_valid}, 2'b10);
    chk(exp_q.size() == 2, "R11", exp_q.size(), 2);
    cur_req = "R5";
    pulse(dl_done);
    while (exp_q.size() != 0) @(negedge clk);
    rel = last_wr_cyc;
    pll_lock = 1;
    while (!ready) @(negedge clk);
    chk(cyc - rel == PLL + 1, "R6", cyc - rel, PLL + 1);
    chk(!busy && !err, "R9", {busy, err}, 0);

    // Clock change, lock mode
    pll_lock = 0; repeat (5) @(negedge clk);
    cur_req = "R10"; clk_mode = 3'b101; lock_mode = 1;
    push_wr(8'hC1, 8'h00); push_wr(8'hC0, 8'h58); push_wr(8'hC1, 8'h01);
    pulse(clk_change_req);
    chk(busy, "R9", busy, 1);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!ready, "R7", ready, 0);
    pll_lock = 1; t0 = cyc;
    while (!ready) @(negedge clk);
    chk(cyc - t0 == 3, "R7", cyc - t0, 3);
    chk(!err, "R7", err, 0);

    // Clock change with no lock: timeout
    pll_lock = 0; repeat (5) @(negedge clk);
    cur_req = "R8";
    push_wr(8'hC1, 8'h00); push_wr(8'hC0, 8'h58); push_wr(8'hC1, 8'h01);
    pulse(clk_change_req);
    while (exp_q.size() != 0) @(negedge clk);
    rel = last_wr_cyc;
    while (!err) @(negedge clk);
    chk(cyc - rel == LTO + 1, "R8", cyc - rel, LTO + 1);
    chk(!ready && !busy && !pdn_n, "R8", {ready, busy, pdn_n}, 0);

    // Restart from error, no options, timer mode
    cur_req = "R5"; ain_en = 0; dl_en = 0; clk_mode = 3'b000; lock_mode = 0;
    push_wr(8'hC0, 8'h00); push_wr(8'hC1, 8'h00); push_wr(8'hC1, 8'h01);
    first_valid_cyc = -1;
    pulse(start);
    t0 = cyc;
    while (first_valid_cyc < 0) @(negedge clk);
    chk(first_valid_cyc - t0 == MS, "R1", first_valid_cyc - t0, MS);
    while (!ready) @(negedge clk);
    chk(exp_q.size() == 0 && !err, "R3", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule